// File: doc/BRIEF.md
# Clause-22 MDIO Management Master

This block lets software talk to Ethernet PHY management registers over a two-wire MDC/MDIO link. One write to the command/status word at offset 0 names the PHY, the register, the direction and (for a write) the 16-bit value. The block then clocks a complete clause-22 management frame out on the wire. The frame is a long run of ones, a start code, an opcode, both addresses, a turnaround and sixteen data bits.

A read frame releases the data line for the turnaround and data phase and shifts the PHY's answer back in. The answer lands in the low half of the same command/status word, which also carries a busy flag and a read-valid flag. Software can poll the busy flag. It can instead wait for the completion interrupt, which is built from a sticky cause bit and an enable bit in a separate mask word.

MDC is a free-running divided copy of the system clock. Outgoing bits change just after MDC falls, and incoming bits are taken just after MDC rises.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Writing offset 0x00 while idle accepts a command. The fields are: value in bits [15:0], PHY address in [20:16], register number in [25:21], and direction in bit 26 (1 = read, 0 = write). Reading offset 0x00 returns these fields in the same positions.
- R2: An accepted command produces a 64-bit frame, MSB first: 32 ones, start 01, opcode 10 for read or 01 for write, 5-bit PHY address, 5-bit register number, then for a write the turnaround 10 and the 16 value bits.
- R3: Bit 28 of offset 0x00 reads 1 from the cycle after a command is accepted until the frame has completed, and reads 0 when idle.
- R4: A write to offset 0x00 while bit 28 is set has no effect on the frame in progress or on the stored fields.
- R5: On completion of a read, bits [15:0] hold the 16 bits sampled from `mdio_i` (first sampled bit in bit 15) and bit 27 reads 1. Bit 27 reads 0 after a write completes and from the acceptance of any new command.
- R6: `mdc` has a period of 2*DIV_HALF system clocks. `mdio_o` and `mdio_oe` change only in the cycle after MDC falls, and `mdio_i` is sampled in the cycle after MDC rises.
- R7: `mdio_oe` is 1 for frame bits 0..45 and, in a write, for bits 46..63. It is 0 during bits 46..63 of a read and whenever no frame is on the wire.
- R8: Bit 4 of the cause word at offset 0x7C sets when a frame completes. A register write with bit 4 = 0 clears it, and a write with bit 4 = 1 leaves it unchanged.
- R9: Bit 4 of the mask word at offset 0x80 is a plain read/write enable. `irq` is 1 exactly when both the cause bit and the mask bit are 1.
- R10: After reset all three words read 0, `mdc` is 0, `mdio_o` is 1, and `mdio_oe` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value, one cycle after the address |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data from the PHY |
| irq | output | 1 | Completion interrupt |

## Verification
The in-RTL properties watch the behaviour that must hold on every cycle. These are the placement of MDC edges and the quiet of `mdio_o`/`mdio_oe` between falling edges. They also cover the line release during a read's turnaround and data, the containment of the engine's activity inside the busy window, and the freezing of stored fields against writes while busy. They further cover cause setting on completion, cause retention on a write of one, and the interrupt gating. What only the bench's scenarios can show is end-to-end content. That means the exact 64-bit frame a PHY model captures for each vector, and the returned read value and read-valid flag. It also means the MDC period measured in clocks, and software-visible sequences such as a second command arriving mid-frame, clear-by-zero of the cause bit, and the interrupt following the mask.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_DW        = 32;
  localparam int VAL_W         = 16;
  localparam int PHY_W         = 5;
  localparam int RNUM_W        = 5;
  localparam int FRAME_BITS    = 64;
  localparam int FIRST_REL_IDX = 46;   // read: line released from this bit
  localparam int FIRST_DAT_IDX = 48;   // read: first sampled data bit

  localparam logic [7:0] OFF_CMD   = 8'h00;
  localparam logic [7:0] OFF_CAUSE = 8'h7C;
  localparam logic [7:0] OFF_MASK  = 8'h80;

  localparam int POS_DIR    = 26;
  localparam int POS_RVALID = 27;
  localparam int POS_BUSY   = 28;
  localparam int POS_DONE   = 4;

  typedef struct packed {
    logic              is_read;
    logic [RNUM_W-1:0] rnum;
    logic [PHY_W-1:0]  phy;
    logic [VAL_W-1:0]  val;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic rise_p,
  output logic fall_p
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CW'(DIV_HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      mdc    <= 1'b0;
      rise_p <= 1'b0;
      fall_p <= 1'b0;
    end else begin
      rise_p <= tick & ~mdc;
      fall_p <= tick & mdc;
      if (tick) begin
        cnt <= '0;
        mdc <= ~mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: edge pulses line up with the level of mdc
  assert_rise_high_R6: assert property (@(posedge clk) disable iff (rst) rise_p |-> mdc);
  assert_fall_low_R6:  assert property (@(posedge clk) disable iff (rst) fall_p |-> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  mdio_cmd_t        cmd,
  input  logic             rise_p,
  input  logic             fall_p,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             busy,
  output logic             done,
  output logic [VAL_W-1:0] rd_val
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic                  pending, active, is_read, mdio_q, oe_q, done_q;
  logic [FRAME_BITS-1:0] sr;
  logic [IDX_W-1:0]      idx;
  logic [VAL_W-1:0]      shin;

  function automatic logic [FRAME_BITS-1:0] build(input mdio_cmd_t c);
    build = {{32{1'b1}}, 2'b01,
             (c.is_read ? 2'b10 : 2'b01),
             c.phy, c.rnum,
             (c.is_read ? 2'b11 : 2'b10),
             c.val};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      active  <= 1'b0;
      is_read <= 1'b0;
      sr      <= '0;
      idx     <= '0;
      shin    <= '0;
      mdio_q  <= 1'b1;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !pending && !active) begin
        pending <= 1'b1;
        is_read <= cmd.is_read;
        sr      <= build(cmd);
      end
      if (fall_p) begin
        if (pending) begin
          pending <= 1'b0;
          active  <= 1'b1;
          idx     <= '0;
          mdio_q  <= sr[FRAME_BITS-1];
          sr      <= sr << 1;
          oe_q    <= 1'b1;
        end else if (active) begin
          if (idx == IDX_W'(FRAME_BITS - 1)) begin
            active <= 1'b0;
            done_q <= 1'b1;
            mdio_q <= 1'b1;
            oe_q   <= 1'b0;
          end else begin
            idx    <= idx + 1'b1;
            mdio_q <= sr[FRAME_BITS-1];
            sr     <= sr << 1;
            oe_q   <= !(is_read && (int'(idx) + 1 >= FIRST_REL_IDX));
          end
        end
      end
      if (rise_p && active && is_read && (int'(idx) >= FIRST_DAT_IDX))
        shin <= {shin[VAL_W-2:0], mdio_i};
    end
  end

  assign mdio_o  = mdio_q;
  assign mdio_oe = oe_q;
  assign busy    = pending | active;
  assign done    = done_q;
  assign rd_val  = shin;

  // R6: line only moves on the cycle after MDC falls
  assert_line_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !fall_p |=> ($stable(mdio_q) && $stable(oe_q)));
  // R7: released during read turnaround/data and when idle
  assert_read_release_R7: assert property (@(posedge clk) disable iff (rst)
    (active && is_read && (int'(idx) >= FIRST_REL_IDX)) |-> !oe_q);
  assert_idle_release_R7: assert property (@(posedge clk) disable iff (rst)
    (!active) |-> !oe_q);
endmodule

// File: rtl/mdio_irq_unit.sv
module mdio_irq_unit (
  input  logic clk,
  input  logic rst,
  input  logic done,
  input  logic cause_wr,
  input  logic mask_wr,
  input  logic wr_bit,
  output logic cause,
  output logic mask,
  output logic irq
);
  logic cause_d, mask_d;

  assign cause_d = done | (cause & ~(cause_wr & ~wr_bit));
  assign mask_d  = mask_wr ? wr_bit : mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause <= 1'b0;
      mask  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      cause <= cause_d;
      mask  <= mask_d;
      irq   <= cause_d & mask_d;
    end
  end

  assert_cause_sets_R8: assert property (@(posedge clk) disable iff (rst) done |=> cause);
  assert_cause_keep_R8: assert property (@(posedge clk) disable iff (rst)
    (cause_wr && wr_bit && !done) |=> (cause == $past(cause)));
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst) irq |-> (cause && mask));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i,
  output logic              irq
);
  logic       sel_cmd, sel_cause, sel_mask, accept;
  logic       rise_p, fall_p, eng_busy, eng_done;
  logic       cause, mask;
  logic       busy_q, rvalid_q;
  logic [VAL_W-1:0] eng_val;
  mdio_cmd_t  cmd_q, new_cmd;

  assign sel_cmd   = (reg_addr == ADDR_W'(OFF_CMD));
  assign sel_cause = (reg_addr == ADDR_W'(OFF_CAUSE));
  assign sel_mask  = (reg_addr == ADDR_W'(OFF_MASK));
  assign accept    = reg_wr && sel_cmd && !busy_q;

  assign new_cmd.is_read = reg_wdata[POS_DIR];
  assign new_cmd.rnum    = reg_wdata[25:21];
  assign new_cmd.phy     = reg_wdata[20:16];
  assign new_cmd.val     = reg_wdata[VAL_W-1:0];

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst(rst), .mdc(mdc), .rise_p(rise_p), .fall_p(fall_p));

  mdio_frame_engine u_eng (
    .clk(clk), .rst(rst), .start(accept), .cmd(new_cmd),
    .rise_p(rise_p), .fall_p(fall_p), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(eng_busy),
    .done(eng_done), .rd_val(eng_val));

  mdio_irq_unit u_irq (
    .clk(clk), .rst(rst), .done(eng_done),
    .cause_wr(reg_wr && sel_cause), .mask_wr(reg_wr && sel_mask),
    .wr_bit(reg_wdata[POS_DONE]), .cause(cause), .mask(mask), .irq(irq));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      busy_q   <= 1'b0;
      rvalid_q <= 1'b0;
    end else if (accept) begin
      cmd_q    <= new_cmd;
      busy_q   <= 1'b1;
      rvalid_q <= 1'b0;
    end else if (eng_done) begin
      busy_q <= 1'b0;
      if (cmd_q.is_read) begin
        cmd_q.val <= eng_val;
        rvalid_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      if (sel_cmd)
        reg_rdata <= {3'b000, busy_q, rvalid_q, cmd_q.is_read, cmd_q.rnum, cmd_q.phy, cmd_q.val};
      else if (sel_cause)
        reg_rdata[POS_DONE] <= cause;
      else if (sel_mask)
        reg_rdata[POS_DONE] <= mask;
    end
  end

  // R3: the engine only runs inside the busy window
  assert_engine_in_busy_R3: assert property (@(posedge clk) disable iff (rst) eng_busy |-> busy_q);
  // R4: a command written while busy leaves the stored fields alone
  assert_ignore_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && reg_wr && sel_cmd) |=> ($stable(cmd_q.phy) && $stable(cmd_q.rnum) && $stable(cmd_q.is_read)));
  // R5: read-valid only rises after a read
  assert_rvalid_read_R5: assert property (@(posedge clk) disable iff (rst) $rose(rvalid_q) |-> cmd_q.is_read);
endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_HALF   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, irq;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  mdio_mgmt_master #(.DIV_HALF(DIV_HALF), .ADDR_W(8)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // PHY model: records the frame, answers reads
  int          bitcnt = 0;
  logic [63:0] seen, oe_seen;
  logic [15:0] resp = '0;

  always @(posedge mdc) begin
    #1;
    if (bitcnt > 0 || mdio_oe) begin
      seen[63-bitcnt]    = mdio_o;
      oe_seen[63-bitcnt] = mdio_oe;
      bitcnt = (bitcnt == 63) ? 0 : bitcnt + 1;
    end
  end

  always @(negedge mdc) begin
    if (bitcnt >= 48) mdio_i = resp[63-bitcnt];
    else              mdio_i = 1'b1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int n = 0; n < 3000; n++) begin
      reg_read(8'h00, v);
      if (!v[28]) return;
    end
  endtask

  function automatic logic [31:0] cmd_word(input logic rd, input logic [4:0] phy,
                                           input logic [4:0] rn, input logic [15:0] d);
    return {5'b0, rd, rn, phy, d};
  endfunction

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] phy,
                                            input logic [4:0] rn, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rn, 2'b10, d};
  endfunction

  // {read, phy, regnum, value, phy answer}
  localparam logic [42:0] VEC [0:5] = '{
    {1'b0, 5'd1,  5'd0,  16'h1234, 16'h0000},
    {1'b1, 5'd3,  5'd2,  16'h0000, 16'hA5C3},
    {1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h0000},
    {1'b1, 5'd0,  5'd31, 16'h5555, 16'h8001},
    {1'b0, 5'd0,  5'd0,  16'h0000, 16'h0000},
    {1'b1, 5'd31, 5'd17, 16'h0000, 16'hFFFF}
  };

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic        op;
    logic [4:0]  phy, rn;
    logic [15:0] wd, rsp;
    realtime     t0;

    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    check("R10 mdc", mdc, 0);
    check("R10 mdio_o", mdio_o, 1);
    check("R10 mdio_oe", mdio_oe, 0);
    check("R10 irq", irq, 0);
    reg_read(8'h00, v); check("R10 cmd word", v, 0);
    reg_read(8'h7C, v); check("R10 cause word", v, 0);
    reg_read(8'h80, v); check("R10 mask word", v, 0);

    // R6 MDC period
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc);
    check("R6 mdc period", 64'(int'(($realtime - t0) / CLK_PERIOD)), 2 * DIV_HALF);

    // Vector walk: R1 R2 R3 R5 R7 R8
    for (int i = 0; i < 6; i++) begin
      {op, phy, rn, wd, rsp} = VEC[i];
      resp = rsp;
      seen = '0; oe_seen = '0;
      reg_write(8'h00, cmd_word(op, phy, rn, wd));
      reg_read(8'h00, v);
      check("R3 busy after accept", v[28], 1);
      wait_idle();
      if (op) begin
        check("R2 read frame header", seen[63:18], exp_frame(1'b1, phy, rn, 16'h0) >> 18);
        check("R7 read oe pattern", oe_seen, {{46{1'b1}}, 18'h0});
      end else begin
        check("R2 write frame", seen, exp_frame(1'b0, phy, rn, wd));
        check("R7 write oe pattern", oe_seen, {64{1'b1}});
      end
      check("R7 oe idle", mdio_oe, 0);
      reg_read(8'h00, v);
      check("R1 fields readback", v[26:16], {op, rn, phy});
      check("R3 busy clear", v[28], 0);
      check("R5 value", v[15:0], op ? rsp : wd);
      check("R5 read-valid", v[27], op);
      reg_read(8'h7C, v); check("R8 cause set", v, 32'h10);
      reg_write(8'h7C, 32'h0);
      reg_read(8'h7C, v); check("R8 cause cleared by 0", v, 0);
    end

    // R4 write while busy ignored
    seen = '0;
    reg_write(8'h00, cmd_word(1'b0, 5'd9, 5'd4, 16'hBEEF));
    reg_write(8'h00, cmd_word(1'b1, 5'd22, 5'd13, 16'h0F0F));
    wait_idle();
    check("R4 frame unchanged", seen, exp_frame(1'b0, 5'd9, 5'd4, 16'hBEEF));
    reg_read(8'h00, v);
    check("R4 fields unchanged", v[26:0], {1'b0, 5'd4, 5'd9, 16'hBEEF});

    // R5 read-valid cleared on new command
    resp = 16'h3C3C;
    reg_write(8'h00, cmd_word(1'b1, 5'd5, 5'd6, 16'h0));
    wait_idle();
    reg_read(8'h00, v); check("R5 read-valid set", {v[27], v[15:0]}, {1'b1, 16'h3C3C});
    reg_write(8'h00, cmd_word(1'b0, 5'd5, 5'd6, 16'h0001));
    reg_read(8'h00, v); check("R5 read-valid cleared on accept", v[27], 0);
    wait_idle();
    reg_read(8'h00, v); check("R5 write leaves read-valid low", v[27], 0);

    // R8 writing 1 keeps cause; R9 mask gating
    check("R9 irq masked", irq, 0);
    reg_write(8'h7C, 32'h10);
    reg_read(8'h7C, v); check("R8 cause kept by 1", v, 32'h10);
    reg_write(8'h80, 32'h10);
    reg_read(8'h80, v); check("R9 mask readback", v, 32'h10);
    check("R9 irq on", irq, 1);
    reg_write(8'h7C, 32'hFFFF_FFEF);
    check("R9 irq off after clear", irq, 0);
    reg_read(8'h7C, v); check("R8 cause cleared", v, 0);
    reg_write(8'h00, cmd_word(1'b0, 5'd1, 5'd1, 16'h0));
    wait_idle();
    @(negedge clk);
    check("R9 irq after completion", irq, 1);
    reg_write(8'h80, 32'h0);
    check("R9 irq off when masked", irq, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule